// File: doc/BRIEF.md
# Two-Wire Sensor Settings Shift Engine

This block loads a 48-bit configuration image into an external sensor and reads it back, using two lines: a serial clock the engine drives, and one bidirectional data line whose output enable the engine controls. The image is assembled from field inputs: an 8-bit detection threshold, a sleep flag, a 2-bit gain step code, a 3-bit filter select code and a spare flag. Every other image bit is zero. A write command shifts the image onto the data line, least significant bit first. Bit 0 is skipped. A fixed 5-bit trailer follows the image. A read command clocks all 48 bits back in and forces the first one, a dummy, to zero.

After each transfer the engine holds a guard interval, and only then does it pulse `done`. When a read finishes, the engine compares the captured image with the image from the most recent write and sets or clears a mismatch flag. All timing counts a one-microsecond tick enable. The defaults therefore give a 1 kHz serial clock and a 30 ms guard, and a bench can shrink both through parameters.

Top module: `sercfg_engine`

## Requirements
- R1: After reset, `scl`, `sda_oe`, `sda_o`, `busy`, `done` and `mismatch` are all 0 and `rd_image` is zero.
- R2: The image has threshold in bits 17:10, sleep flag in bit 18, gain code in bits 20:19, filter code in bits 23:21 and spare flag in bit 24. Bits 9:0 and 47:25 are zero.
- R3: A write drives image bits 1 through 47 in ascending order, then the trailer 0,1,1,0,1. That is 52 clock periods. Each bit is on `sda_o` before the rising edge of `scl` that carries it, and `sda_oe` is 1 while those bits are clocked.
- R4: Each clock period is `HALF_TICKS` ticks high followed by `HALF_TICKS` ticks low. A cycle without `tick_us` changes neither `scl` nor the position within the transfer.
- R5: A read runs 48 clock periods with `sda_oe` at 0 and samples `sda_i` at the end of each high half. Image bit k takes the k-th sample, counting from 0, except bit 0, which is forced to 0.
- R6: After the last falling clock edge, `busy` stays high for `GUARD_TICKS` more ticks. `done` is then a one-cycle pulse in the first cycle with `busy` low. With a tick every cycle, `busy` lasts 1 + 2·`HALF_TICKS`·N + `GUARD_TICKS` cycles, where N is the number of clock periods.
- R7: When a read completes, `mismatch` becomes 1 if any of the 48 captured bits differs from the last written image, and 0 otherwise. It changes at no other time.
- R8: `wr_start` and `rd_start` pulses that arrive while `busy` is high are ignored. They do not change the transfer in progress and do not start a later one.
- R9: If `wr_start` and `rd_start` arrive together while idle, the write is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-microsecond timing enable |
| wr_start | input | 1 | Start a settings write (pulse) |
| rd_start | input | 1 | Start a settings read-back (pulse) |
| thresh | input | 8 | Detection threshold field |
| sleep_flag | input | 1 | Sleep flag field |
| gain_code | input | 2 | Gain step code field |
| filt_code | input | 3 | Filter select code field |
| aux_flag | input | 1 | Spare flag field |
| sda_i | input | 1 | Data line input value |
| scl | output | 1 | Serial clock to the sensor |
| sda_o | output | 1 | Data line output value |
| sda_oe | output | 1 | Data line output enable |
| busy | output | 1 | Transfer or guard interval in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| mismatch | output | 1 | Last read differed from last written image |
| rd_image | output | 48 | Image captured by the last read |

## Verification
The embedded properties watch on every cycle that the clock idles low and the data line is released when idle and during reads. They also check that data never moves on a rising clock edge, that a cycle without a tick leaves the clock unchanged, that `done` only closes a busy interval, and that the mismatch flag only changes with `done`. The bench's sensor model is needed for the rest: the exact wire order of image and trailer, the dummy-bit handling, the total transfer and guard lengths, and the comparison result with clean and corrupted read-back data. Its scenarios also cover strobes injected mid-transfer and simultaneous strobes.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;

    localparam int IMG_W     = 48;
    localparam int TRL_W     = 5;
    // trailer in wire order 0,1,1,0,1 stored LSB first
    localparam logic [TRL_W-1:0] TRAILER = 5'b10110;

    localparam int THR_LSB   = 10;
    localparam int THR_W     = 8;
    localparam int SLEEP_POS = 18;
    localparam int GAIN_LSB  = 19;
    localparam int GAIN_W    = 2;
    localparam int FILT_LSB  = 21;
    localparam int FILT_W    = 3;
    localparam int AUX_POS   = 24;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_GUARD
    } state_e;

    typedef enum logic {
        OP_WR,
        OP_RD
    } op_e;

    typedef struct packed {
        logic [THR_W-1:0]  thresh;
        logic              sleep;
        logic [GAIN_W-1:0] gain;
        logic [FILT_W-1:0] filt;
        logic              aux;
    } fields_t;

    function automatic logic [IMG_W-1:0] pack_image(input fields_t f);
        logic [IMG_W-1:0] img;
        img = '0;
        img[THR_LSB +: THR_W]   = f.thresh;
        img[SLEEP_POS]          = f.sleep;
        img[GAIN_LSB +: GAIN_W] = f.gain;
        img[FILT_LSB +: FILT_W] = f.filt;
        img[AUX_POS]            = f.aux;
        return img;
    endfunction

endpackage

// File: rtl/sercfg_timer.sv
module sercfg_timer #(
    parameter int CW = 15
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          hit
);

    logic [CW-1:0] cnt;

    assign hit = tick && !clear && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || clear || hit) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    // R4: the interval count never reaches the active limit
    p_cnt_below_limit_r4: assert property (@(posedge clk) disable iff (rst)
        cnt < limit);

endmodule

// File: rtl/sercfg_pack.sv
module sercfg_pack
    import sercfg_pkg::*;
(
    input  fields_t          fields,
    output logic [IMG_W-1:0] image
);

    assign image = pack_image(fields);

endmodule

// File: rtl/sercfg_cmp.sv
module sercfg_cmp #(
    parameter int W = 48
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         differ
);

    logic [W-1:0] bit_diff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign bit_diff[i] = a[i] ^ b[i];
    end

    assign differ = |bit_diff;

endmodule

// File: rtl/sercfg_engine.sv
module sercfg_engine
    import sercfg_pkg::*;
#(
    parameter int HALF_TICKS  = 500,
    parameter int GUARD_TICKS = 30000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_us,
    input  logic             wr_start,
    input  logic             rd_start,
    input  logic [7:0]       thresh,
    input  logic             sleep_flag,
    input  logic [1:0]       gain_code,
    input  logic [2:0]       filt_code,
    input  logic             aux_flag,
    input  logic             sda_i,
    output logic             scl,
    output logic             sda_o,
    output logic             sda_oe,
    output logic             busy,
    output logic             done,
    output logic             mismatch,
    output logic [IMG_W-1:0] rd_image
);

    localparam int TX_W    = IMG_W + TRL_W;
    localparam int SH_W    = TX_W - 1;
    localparam int IDX_W   = $clog2(TX_W);
    localparam int WR_LAST = TX_W - 1;
    localparam int RD_LAST = IMG_W - 1;
    localparam int MAXT    = (GUARD_TICKS > HALF_TICKS) ? GUARD_TICKS : HALF_TICKS;
    localparam int TCW     = $clog2(MAXT + 1);

    state_e           state;
    op_e              op;
    logic [IDX_W-1:0] idx;
    logic [SH_W-1:0]  tx_sh;
    logic [IMG_W-1:0] wr_img;
    logic [IMG_W-1:0] rx;
    logic [IMG_W-1:0] new_img;
    fields_t          fields;
    logic             hit;
    logic             differ;
    logic             last_bit;
    logic             tmr_clear;
    logic [TCW-1:0]   tmr_limit;

    assign fields = '{thresh: thresh, sleep: sleep_flag, gain: gain_code,
                      filt: filt_code, aux: aux_flag};

    sercfg_pack u_pack (
        .fields (fields),
        .image  (new_img)
    );

    assign tmr_clear = (state == ST_IDLE) || (state == ST_LEAD);
    assign tmr_limit = (state == ST_GUARD) ? TCW'(GUARD_TICKS) : TCW'(HALF_TICKS);

    sercfg_timer #(.CW(TCW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (tmr_clear),
        .tick  (tick_us),
        .limit (tmr_limit),
        .hit   (hit)
    );

    sercfg_cmp #(.W(IMG_W)) u_cmp (
        .a      (rx),
        .b      (wr_img),
        .differ (differ)
    );

    assign last_bit = (op == OP_WR) ? (idx == IDX_W'(WR_LAST))
                                    : (idx == IDX_W'(RD_LAST));
    assign busy     = (state != ST_IDLE);
    assign rd_image = rx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            op       <= OP_WR;
            idx      <= '0;
            tx_sh    <= '0;
            wr_img   <= '0;
            rx       <= '0;
            scl      <= 1'b0;
            sda_o    <= 1'b0;
            sda_oe   <= 1'b0;
            done     <= 1'b0;
            mismatch <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (wr_start) begin
                        op     <= OP_WR;
                        wr_img <= new_img;
                        tx_sh  <= {TRAILER, new_img[IMG_W-1:1]};
                        sda_o  <= new_img[1];
                        sda_oe <= 1'b1;
                        idx    <= IDX_W'(1);
                        state  <= ST_LEAD;
                    end else if (rd_start) begin
                        op     <= OP_RD;
                        rx     <= '0;
                        sda_o  <= 1'b0;
                        sda_oe <= 1'b0;
                        idx    <= '0;
                        state  <= ST_LEAD;
                    end
                end
                ST_LEAD: begin
                    scl   <= 1'b1;
                    state <= ST_HIGH;
                end
                ST_HIGH: begin
                    if (hit) begin
                        scl   <= 1'b0;
                        state <= ST_LOW;
                        if (op == OP_RD) begin
                            rx <= {(idx != '0) && sda_i, rx[IMG_W-1:1]};
                        end else if (!last_bit) begin
                            tx_sh <= tx_sh >> 1;
                            sda_o <= tx_sh[1];
                        end
                    end
                end
                ST_LOW: begin
                    if (hit) begin
                        if (last_bit) begin
                            sda_oe <= 1'b0;
                            sda_o  <= 1'b0;
                            state  <= ST_GUARD;
                        end else begin
                            idx   <= idx + 1'b1;
                            scl   <= 1'b1;
                            state <= ST_HIGH;
                        end
                    end
                end
                ST_GUARD: begin
                    if (hit) begin
                        done  <= 1'b1;
                        state <= ST_IDLE;
                        if (op == OP_RD) begin
                            mismatch <= differ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R1: clock and data driver are quiet while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl && !sda_oe));

    // R3: data never changes on the rising clock edge of a write
    p_setup_before_rise_r3: assert property (@(posedge clk) disable iff (rst)
        (sda_oe && $rose(scl)) |-> $stable(sda_o));

    // R4: no tick, no clock movement
    p_tick_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick_us && state != ST_LEAD) |=> $stable(scl));

    // R5: data line released for reads
    p_read_released_r5: assert property (@(posedge clk) disable iff (rst)
        (busy && op == OP_RD) |-> !sda_oe);

    // R6: done closes a busy interval
    p_done_after_busy_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R7: mismatch only moves together with done
    p_mismatch_with_done_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(mismatch) |-> done);

    // R8: a write strobe during a transfer leaves the written image alone
    p_ignore_busy_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_start) |=> $stable(wr_img));

endmodule

// File: tb/sercfg_engine_bench.sv
module sercfg_engine_bench;

    localparam int HALF  = 4;
    localparam int GUARD = 20;
    localparam int WR_N  = 52;
    localparam int RD_N  = 48;
    localparam int WR_CYC = 1 + WR_N * 2 * HALF + GUARD;
    localparam int RD_CYC = 1 + RD_N * 2 * HALF + GUARD;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_us = 1'b1;
    logic wr_start = 1'b0;
    logic rd_start = 1'b0;
    logic [7:0] thresh = 8'd0;
    logic sleep_flag = 1'b0;
    logic [1:0] gain_code = 2'd0;
    logic [2:0] filt_code = 3'd0;
    logic aux_flag = 1'b0;
    logic sda_i;
    logic scl, sda_o, sda_oe, busy, done, mismatch;
    logic [47:0] rd_image;

    int n_tests = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sercfg_engine #(.HALF_TICKS(HALF), .GUARD_TICKS(GUARD)) u_sercfg_engine (
        .clk(clk), .rst(rst), .tick_us(tick_us),
        .wr_start(wr_start), .rd_start(rd_start),
        .thresh(thresh), .sleep_flag(sleep_flag), .gain_code(gain_code),
        .filt_code(filt_code), .aux_flag(aux_flag), .sda_i(sda_i),
        .scl(scl), .sda_o(sda_o), .sda_oe(sda_oe), .busy(busy), .done(done),
        .mismatch(mismatch), .rd_image(rd_image)
    );

    // sensor model: captures written bits on rising clock, serves read bits
    logic [63:0] cap;
    int ncap = 0;
    logic [47:0] mimg = '0;
    int ridx = 0;

    always @(posedge scl) begin
        if (sda_oe) begin
            cap[ncap] = sda_o;
            ncap = ncap + 1;
        end
    end

    always @(negedge scl) begin
        if (!sda_oe) ridx = ridx + 1;
    end

    assign sda_i = (ridx < 48) ? mimg[ridx] : 1'b0;

    function automatic logic [47:0] pack(input logic [7:0] t, input logic s,
                                         input logic [1:0] g, input logic [2:0] f,
                                         input logic a);
        logic [47:0] v;
        v = '0;
        v[17:10] = t;
        v[18] = s;
        v[20:19] = g;
        v[23:21] = f;
        v[24] = a;
        return v;
    endfunction

    function automatic logic [63:0] wire_bits(input logic [47:0] img);
        logic [63:0] w;
        w = '0;
        for (int i = 1; i < 48; i++) w[i-1] = img[i];
        w[47] = 1'b0; w[48] = 1'b1; w[49] = 1'b1; w[50] = 1'b0; w[51] = 1'b1;
        return w;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_fields(input logic [7:0] t, input logic s, input logic [1:0] g,
                              input logic [2:0] f, input logic a);
        thresh = t; sleep_flag = s; gain_code = g; filt_code = f; aux_flag = a;
    endtask

    task automatic xfer(input bit do_wr, input bit do_rd, input int inj_at,
                        input int gap_at, input int gap_len,
                        output int cyc, output int hi, output bit dn,
                        output bit moved, output bit oe_seen);
        logic ref_scl;
        ref_scl = 1'b0;
        @(negedge clk);
        ncap = 0; ridx = 0;
        wr_start = do_wr; rd_start = do_rd;
        @(negedge clk);
        wr_start = 1'b0; rd_start = 1'b0;
        cyc = 0; hi = 0; moved = 1'b0; oe_seen = 1'b0;
        while (busy && cyc < 5000) begin
            cyc++;
            if (scl) hi++;
            if (sda_oe) oe_seen = 1'b1;
            if (gap_len > 0 && cyc > gap_at && cyc <= gap_at + gap_len && scl !== ref_scl)
                moved = 1'b1;
            if (gap_len > 0 && cyc == gap_at) begin ref_scl = scl; tick_us = 1'b0; end
            if (gap_len > 0 && cyc == gap_at + gap_len) tick_us = 1'b1;
            if (inj_at > 0 && cyc == inj_at) begin
                wr_start = 1'b1; rd_start = 1'b1; thresh = ~thresh;
            end else begin
                wr_start = 1'b0; rd_start = 1'b0;
            end
            @(negedge clk);
        end
        if (cyc >= 5000) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog transfer hung actual=%0d expected=%0d", cyc, 0);
        end
        dn = done;
    endtask

    int cyc, hi;
    bit dn, moved, oe_seen;
    logic [47:0] img, bad;

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset outputs", {58'd0, scl, sda_o, sda_oe, busy, done, mismatch}, 64'd0);
        chk("R1 reset rd_image", {16'd0, rd_image}, 64'd0);

        // directed write, default-like settings
        set_fields(8'd56, 1'b0, 2'd3, 3'd0, 1'b1);
        img = pack(8'd56, 1'b0, 2'd3, 3'd0, 1'b1);
        xfer(1, 0, 0, 0, 0, cyc, hi, dn, moved, oe_seen);
        chk("R6 write busy length", cyc, WR_CYC);
        chk("R6 done pulse", dn, 1);
        @(negedge clk);
        chk("R6 done single cycle", done, 0);
        chk("R3 write bit count", ncap, WR_N);
        chk("R3 write wire order", cap[51:0], wire_bits(img) & 64'hF_FFFF_FFFF_FFFF);
        chk("R2 threshold on wire", cap[16:9], 8'd56);
        chk("R2 gain and spare on wire", {cap[23], cap[19:18]}, 3'b111);
        chk("R4 clock high ticks", hi, WR_N * HALF);

        // read back with dummy bit set in the model
        mimg = img | 48'd1;
        xfer(0, 1, 0, 0, 0, cyc, hi, dn, moved, oe_seen);
        chk("R6 read busy length", cyc, RD_CYC);
        chk("R5 read keeps oe low", oe_seen, 0);
        chk("R5 read clock high ticks", hi, RD_N * HALF);
        chk("R5 read image dummy forced", rd_image, img);
        chk("R7 clean read no mismatch", mismatch, 0);

        // corrupted reserved bit
        mimg = img ^ (48'd1 << 30);
        xfer(0, 1, 0, 0, 0, cyc, hi, dn, moved, oe_seen);
        chk("R7 reserved bit flip mismatch", mismatch, 1);
        chk("R5 captured flip", rd_image, mimg);
        mimg = img;
        xfer(0, 1, 0, 0, 0, cyc, hi, dn, moved, oe_seen);
        chk("R7 mismatch clears", mismatch, 0);

        // R4 tick gap during first clock high
        xfer(1, 0, 0, 3, 7, cyc, hi, dn, moved, oe_seen);
        chk("R4 gap extends transfer", cyc, WR_CYC + 7);
        chk("R4 clock frozen in gap", moved, 0);
        chk("R4 wire data unaffected", cap[51:0], wire_bits(img) & 64'hF_FFFF_FFFF_FFFF);

        // R8 strobes mid-write ignored
        xfer(1, 0, 100, 0, 0, cyc, hi, dn, moved, oe_seen);
        chk("R8 write length with strobe", cyc, WR_CYC);
        chk("R8 write data with strobe", cap[51:0], wire_bits(img) & 64'hF_FFFF_FFFF_FFFF);
        repeat (3) @(negedge clk);
        chk("R8 no queued transfer", busy, 0);
        thresh = 8'd56;

        // R8 strobe during read
        mimg = img;
        xfer(0, 1, 50, 0, 0, cyc, hi, dn, moved, oe_seen);
        chk("R8 read length with strobe", cyc, RD_CYC);
        chk("R8 no write bits during read", ncap, 0);
        chk("R8 read result intact", mismatch, 0);
        thresh = 8'd56;

        // R9 simultaneous strobes
        xfer(1, 1, 0, 0, 0, cyc, hi, dn, moved, oe_seen);
        chk("R9 write wins length", cyc, WR_CYC);
        chk("R9 write wins bits", ncap, WR_N);

        // random settings
        for (int k = 0; k < 8; k++) begin
            logic [7:0] t; logic s; logic [1:0] g; logic [2:0] f; logic a;
            int fb;
            t = 8'($urandom); s = 1'($urandom); g = 2'($urandom);
            f = 3'($urandom); a = 1'($urandom);
            set_fields(t, s, g, f, a);
            img = pack(t, s, g, f, a);
            xfer(1, 0, 0, 0, 0, cyc, hi, dn, moved, oe_seen);
            chk("R3 random write wire order", cap[51:0], wire_bits(img) & 64'hF_FFFF_FFFF_FFFF);
            mimg = img | 48'($urandom % 2);
            xfer(0, 1, 0, 0, 0, cyc, hi, dn, moved, oe_seen);
            chk("R5 random read image", rd_image, img);
            chk("R7 random match", mismatch, 0);
            fb = 1 + ($urandom % 47);
            bad = img ^ (48'd1 << fb);
            mimg = bad;
            xfer(0, 1, 0, 0, 0, cyc, hi, dn, moved, oe_seen);
            chk("R7 random flipped bit mismatch", mismatch, 1);
            chk("R5 random flipped capture", rd_image, bad);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog global timeout actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule